// File: doc/BRIEF.md
# Transmit Descriptor Status and Early-Start Unit

This block holds the status word of one transmit descriptor in a simple Fast Ethernet controller and decides when the packet behind that descriptor may start onto the wire. The host sees a single 32-bit register. It can change that register only with full double-word writes. Each such write loads a new byte size, a new ownership flag and a new early-start threshold code. The same write wipes every result bit the hardware had set for the previous packet.

The MAC and DMA sides report events as single-cycle pulses: DMA done, good completion, FIFO underrun, abort, carrier loss, late collision, collision, and missing heartbeat. The unit turns these into sticky flags and a saturating collision count.

A separate path compares the transmit FIFO fill level against the decoded threshold. It also watches a complete-packet flag. It raises a one-cycle start pulse once per loaded descriptor. A queue-gating output holds back the next descriptor while an oversized packet has not yet been handed back by the DMA.

Top module: `txdesc_status_unit`

## Requirements
- R1: After reset, `host_rdata` reads 0x00002000, with only the ownership bit (bit 13) at 1. `tx_start` is 0 and `next_desc_valid` is 1.
- R2: A write with `host_be` = 4'b1111 loads bits 12..0 (byte size), bit 13 (ownership) and bits 21..16 (threshold code). These take effect on the next clock. Bits 23..22 always read 0, and the values written to bits 31..24 and 15..14 are not stored.
- R3: A write whose `host_be` is anything other than 4'b1111 changes nothing in the register.
- R4: An accepted write clears bit 31 (carrier lost), bit 30 (abort), bit 29 (late collision), bit 28 (heartbeat missing), bits 27..24 (collision count), bit 15 (sent OK) and bit 14 (underrun). In that cycle the write overrides every event input, including `ev_dma_done`.
- R5: `ev_carrier_lost` sets bit 31, `ev_abort` sets bit 30, `ev_late_coll` sets bit 29 and `ev_dma_done` sets bit 13. Each bit stays set until the next accepted write.
- R6: Bits 27..24 increment by one on each `ev_coll` pulse while `tx_active` is 1, and hold at 15. A pulse while `tx_active` is 0 has no effect.
- R7: The start threshold is 8 bytes for code 0. For any other code it is code × `THR_UNIT` bytes, limited to `THR_MAX` (2048) bytes.
- R8: After an accepted write with bit 13 = 0, the unit is armed. `tx_start` is high for exactly one cycle, on the clock after `fifo_bytes` ≥ threshold or `fifo_pkt_ready` = 1 is first sampled. It then stays low until the next such write. It never fires while the unit is not armed.
- R9: `ev_underrun` sets bit 14 and clears bit 15. `ev_tx_ok` sets bit 15 only if bit 14 is 0 and no underrun arrives in the same cycle.
- R10: `ev_hb_missing` sets bit 28 only while `mode_100m` is 0. While `mode_100m` is 1, bit 28 is cleared.
- R11: `next_desc_valid` is 0 exactly when the byte size is greater than `LONG_LIMIT` (1792) and bit 13 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current register value |
| ev_dma_done | input | 1 | DMA for this descriptor finished |
| ev_tx_ok | input | 1 | Packet completed on the wire |
| ev_underrun | input | 1 | FIFO ran empty during the packet |
| ev_abort | input | 1 | Packet aborted |
| ev_carrier_lost | input | 1 | Carrier dropped during the packet |
| ev_late_coll | input | 1 | Collision outside the collision window |
| ev_coll | input | 1 | One collision pulse |
| ev_hb_missing | input | 1 | No collision-detect pulse in the post-packet window |
| tx_active | input | 1 | A packet is being transmitted |
| mode_100m | input | 1 | Link runs at 100 Mbps |
| fifo_bytes | input | FIFO_W | Bytes held in the transmit FIFO |
| fifo_pkt_ready | input | 1 | FIFO holds at least one whole packet |
| tx_start | output | 1 | One-cycle start-transmit pulse |
| next_desc_valid | output | 1 | Next descriptor may be queued |

## Verification
The bench builds the unit with `THR_UNIT` = 64 and leaves the other parameters at their defaults. With a 6-bit code and the default unit of 32 bytes, the largest product is 2016, so the 2048-byte limit can never act. Doubling the unit lets code 63 request 4032 bytes, so the clamp path is exercised: the start pulse must appear at exactly 2048 bytes and not one byte earlier. The 1792-byte gating boundary and the 8-byte code-0 threshold are exercised at their edge values under the default limits.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int REG_W   = 32;
  localparam int SIZE_W  = 13;
  localparam int CODE_W  = 6;
  localparam int CNT_W   = 4;
  localparam int BE_W    = REG_W / 8;

  localparam int SIZE_LSB = 0;
  localparam int OWN_BIT  = 13;
  localparam int TUN_BIT  = 14;
  localparam int TOK_BIT  = 15;
  localparam int CODE_LSB = 16;
  localparam int CNT_LSB  = 24;

  typedef struct packed {
    logic dma_done;
    logic tx_ok;
    logic underrun;
    logic abort;
    logic crs_lost;
    logic late_coll;
    logic hb_missing;
  } txd_events_t;

  typedef struct packed {
    logic crs_lost;
    logic abort;
    logic late_coll;
    logic hb_fail;
    logic tok;
    logic tun;
  } txd_flags_t;
endpackage

// File: rtl/txd_sat_counter.sv
module txd_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && count != TOP)   count <= count + 1'b1;
  end

  // R6: once at the top, only a clear moves the count
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !clr) |=> count == TOP);
endmodule

// File: rtl/txd_thresh_decode.sv
module txd_thresh_decode #(
  parameter int CODE_W = 6,
  parameter int UNIT   = 32,
  parameter int BASE   = 8,
  parameter int MAXB   = 2048,
  parameter int OUT_W  = 12
) (
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  thr
);
  localparam int RAW_W  = CODE_W + $clog2(UNIT) + 1;
  localparam int LIM_W  = $clog2(MAXB + 1) + 1;
  localparam int PROD_W = (RAW_W > LIM_W) ? RAW_W : LIM_W;

  logic [PROD_W-1:0] prod;

  generate
    if ((UNIT & (UNIT - 1)) == 0) begin : g_shift
      assign prod = PROD_W'(code) << $clog2(UNIT);
    end else begin : g_mult
      assign prod = PROD_W'(code) * PROD_W'(UNIT);
    end
  endgenerate

  always_comb begin
    if (code == '0)                 thr = OUT_W'(BASE);
    else if (prod > PROD_W'(MAXB))  thr = OUT_W'(MAXB);
    else                            thr = OUT_W'(prod);
  end
endmodule

// File: rtl/txd_start_ctrl.sv
module txd_start_ctrl #(
  parameter int FIFO_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [FIFO_W-1:0] fifo_bytes,
  input  logic [FIFO_W-1:0] thr,
  input  logic              pkt_ready,
  output logic              start
);
  logic armed;
  logic reached;

  assign reached = (fifo_bytes >= thr) || pkt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= armed && reached;
      if (arm)                  armed <= 1'b1;
      else if (armed && reached) armed <= 1'b0;
    end
  end

  // R8: the start pulse is never wider than one clock
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !arm) |=> !start);

  // R8: an unarmed unit stays quiet on the next clock
  assert_no_start_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !start);
endmodule

// File: rtl/txd_status_reg.sv
module txd_status_reg
  import txd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic [REG_W-1:0]  wdata,
  input  txd_events_t       ev,
  input  logic              mode_100m,
  input  logic [CNT_W-1:0]  coll_cnt,
  output logic [SIZE_W-1:0] size,
  output logic              own,
  output logic [CODE_W-1:0] code,
  output logic [REG_W-1:0]  rdata
);
  txd_flags_t flags;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[REG_W-1:CODE_LSB+CODE_W], wdata[TOK_BIT:TUN_BIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size  <= '0;
      own   <= 1'b1;
      code  <= '0;
      flags <= '0;
    end else if (wr_accept) begin
      size  <= wdata[SIZE_LSB +: SIZE_W];
      own   <= wdata[OWN_BIT];
      code  <= wdata[CODE_LSB +: CODE_W];
      flags <= '0;
    end else begin
      if (ev.dma_done)  own             <= 1'b1;
      if (ev.crs_lost)  flags.crs_lost  <= 1'b1;
      if (ev.abort)     flags.abort     <= 1'b1;
      if (ev.late_coll) flags.late_coll <= 1'b1;
      if (mode_100m)          flags.hb_fail <= 1'b0;
      else if (ev.hb_missing) flags.hb_fail <= 1'b1;
      if (ev.underrun) begin
        flags.tun <= 1'b1;
        flags.tok <= 1'b0;
      end else if (ev.tx_ok && !flags.tun) begin
        flags.tok <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[SIZE_LSB +: SIZE_W] = size;
    rdata[OWN_BIT]            = own;
    rdata[TUN_BIT]            = flags.tun;
    rdata[TOK_BIT]            = flags.tok;
    rdata[CODE_LSB +: CODE_W] = code;
    rdata[CNT_LSB +: CNT_W]   = coll_cnt;
    rdata[REG_W-1 -: 4]       = {flags.crs_lost, flags.abort, flags.late_coll, flags.hb_fail};
  end

  // R4: after an accepted write every result field reads zero
  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (rdata[REG_W-1:CNT_LSB] == '0 && rdata[TOK_BIT:TUN_BIT] == 2'b00));

  // R9: sent-OK and underrun are never reported together
  assert_tok_tun_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[TOK_BIT] |-> !rdata[TUN_BIT]);

  // R10: heartbeat flag stays low in 100 Mbps mode
  assert_hb_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_100m |=> !rdata[REG_W-4]);
endmodule

// File: rtl/txdesc_status_unit.sv
module txdesc_status_unit
  import txd_pkg::*;
#(
  parameter int THR_UNIT   = 32,
  parameter int THR_BASE   = 8,
  parameter int THR_MAX    = 2048,
  parameter int FIFO_W     = 12,
  parameter int LONG_LIMIT = 1792
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              ev_dma_done,
  input  logic              ev_tx_ok,
  input  logic              ev_underrun,
  input  logic              ev_abort,
  input  logic              ev_carrier_lost,
  input  logic              ev_late_coll,
  input  logic              ev_coll,
  input  logic              ev_hb_missing,
  input  logic              tx_active,
  input  logic              mode_100m,
  input  logic [FIFO_W-1:0] fifo_bytes,
  input  logic              fifo_pkt_ready,
  output logic              tx_start,
  output logic              next_desc_valid
);
  localparam logic [SIZE_W-1:0] LONG_SZ = SIZE_W'(LONG_LIMIT);

  logic              wr_accept;
  txd_events_t       ev;
  logic [SIZE_W-1:0] size;
  logic              own;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  coll_cnt;
  logic [FIFO_W-1:0] thr;

  assign wr_accept = host_wr_en && (host_be == {BE_W{1'b1}});

  assign ev = '{dma_done:   ev_dma_done,
                tx_ok:      ev_tx_ok,
                underrun:   ev_underrun,
                abort:      ev_abort,
                crs_lost:   ev_carrier_lost,
                late_coll:  ev_late_coll,
                hb_missing: ev_hb_missing};

  txd_sat_counter #(.W(CNT_W)) coll_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_accept),
    .inc   (ev_coll && tx_active),
    .count (coll_cnt)
  );

  txd_status_reg reg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (wr_accept),
    .wdata     (host_wdata),
    .ev        (ev),
    .mode_100m (mode_100m),
    .coll_cnt  (coll_cnt),
    .size      (size),
    .own       (own),
    .code      (code),
    .rdata     (host_rdata)
  );

  txd_thresh_decode #(
    .CODE_W (CODE_W),
    .UNIT   (THR_UNIT),
    .BASE   (THR_BASE),
    .MAXB   (THR_MAX),
    .OUT_W  (FIFO_W)
  ) thr_i (
    .code (code),
    .thr  (thr)
  );

  txd_start_ctrl #(.FIFO_W(FIFO_W)) start_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (wr_accept && !host_wdata[OWN_BIT]),
    .fifo_bytes (fifo_bytes),
    .thr        (thr),
    .pkt_ready  (fifo_pkt_ready),
    .start      (tx_start)
  );

  assign next_desc_valid = (size <= LONG_SZ) || own;

  // R3: a partial write with no events leaves the register unchanged
  assert_partial_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_be != 4'hF && ev == '0 && !ev_coll && !mode_100m)
      |=> $stable(host_rdata));

  // R11: a held-back queue stays held until DMA completion or a new write
  assert_long_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!next_desc_valid && !ev_dma_done && !wr_accept) |=> !next_desc_valid);
endmodule

// File: tb/txdesc_status_unit_tb_top.sv
`timescale 1ns/1ps
module txdesc_status_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_en = 0;
  logic [3:0] host_be = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic [7:0] evb = 0;
  logic tx_active = 0, mode_100m = 0, fifo_pkt_ready = 0;
  logic [11:0] fifo_bytes = 0;
  logic tx_start, next_desc_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txdesc_status_unit #(.THR_UNIT(64)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .ev_dma_done(evb[7]), .ev_tx_ok(evb[6]), .ev_underrun(evb[5]),
    .ev_abort(evb[4]), .ev_carrier_lost(evb[3]), .ev_late_coll(evb[2]),
    .ev_coll(evb[1]), .ev_hb_missing(evb[0]),
    .tx_active(tx_active), .mode_100m(mode_100m),
    .fifo_bytes(fifo_bytes), .fifo_pkt_ready(fifo_pkt_ready),
    .tx_start(tx_start), .next_desc_valid(next_desc_valid)
  );

  localparam bit [7:0] E_DMA = 8'h80, E_TOK = 8'h40, E_TUN = 8'h20, E_ABT = 8'h10,
                       E_CRS = 8'h08, E_OWC = 8'h04, E_COL = 8'h02, E_HB = 8'h01;

  typedef struct packed {
    bit        wr;
    bit [3:0]  be;
    bit [31:0] wd;
    bit [7:0]  ev;
    bit        act;
    bit        m100;
    bit [11:0] fb;
    bit        pkt;
    bit [31:0] er;
    bit        es;
    bit        evld;
    bit [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1, 4'hF, 32'h00020064, 8'h00, 0, 0, 12'd0,    0, 32'h00020064, 0, 1, 4'd2},  // R2 load, code 2 = 128 B
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd127,  0, 32'h00020064, 0, 1, 4'd7},  // R7 one below threshold
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd128,  0, 32'h00020064, 1, 1, 4'd8},  // R8 threshold reached
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd200,  0, 32'h00020064, 0, 1, 4'd8},  // R8 single pulse
    '{0, 4'h0, 32'h0,        E_COL, 1, 0, 12'd0,    0, 32'h01020064, 0, 1, 4'd6},  // R6 count while active
    '{0, 4'h0, 32'h0,        E_COL, 0, 0, 12'd0,    0, 32'h01020064, 0, 1, 4'd6},  // R6 ignored when idle
    '{0, 4'h0, 32'h0, E_CRS|E_ABT|E_OWC, 0, 0, 12'd0, 0, 32'hE1020064, 0, 1, 4'd5}, // R5 sticky flags
    '{0, 4'h0, 32'h0,        E_TOK, 0, 0, 12'd0,    0, 32'hE1028064, 0, 1, 4'd9},  // R9 sent OK
    '{0, 4'h0, 32'h0,        E_TUN, 0, 0, 12'd0,    0, 32'hE1024064, 0, 1, 4'd9},  // R9 underrun clears OK
    '{0, 4'h0, 32'h0,        E_TOK, 0, 0, 12'd0,    0, 32'hE1024064, 0, 1, 4'd9},  // R9 OK blocked by underrun
    '{0, 4'h0, 32'h0,        E_HB,  0, 0, 12'd0,    0, 32'hF1024064, 0, 1, 4'd10}, // R10 heartbeat at 10 Mbps
    '{0, 4'h0, 32'h0,        8'h00, 0, 1, 12'd0,    0, 32'hE1024064, 0, 1, 4'd10}, // R10 cleared at 100 Mbps
    '{1, 4'h7, 32'h00000000, 8'h00, 0, 0, 12'd0,    0, 32'hE1024064, 0, 1, 4'd3},  // R3 partial write ignored
    '{0, 4'h0, 32'h0,        E_DMA, 0, 0, 12'd0,    0, 32'hE1026064, 0, 1, 4'd5},  // R5 DMA done sets owner
    '{1, 4'hF, 32'hFFFF07D0, E_COL|E_CRS, 1, 0, 12'd0, 0, 32'h003F07D0, 0, 0, 4'd4}, // R4 write beats events, R11 long
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd2047, 0, 32'h003F07D0, 0, 0, 4'd7},  // R7 clamp, one byte short
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd2048, 0, 32'h003F07D0, 1, 0, 4'd7},  // R7 clamp at 2048
    '{0, 4'h0, 32'h0,        E_DMA, 0, 0, 12'd0,    0, 32'h003F27D0, 0, 1, 4'd11}, // R11 released by owner
    '{1, 4'hF, 32'h00000700, 8'h00, 0, 0, 12'd0,    0, 32'h00000700, 0, 1, 4'd11}, // R11 1792 not long
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd7,    0, 32'h00000700, 0, 1, 4'd7},  // R7 code 0 below 8
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd8,    0, 32'h00000700, 1, 1, 4'd7},  // R7 code 0 at 8
    '{1, 4'hF, 32'h00050040, 8'h00, 0, 0, 12'd0,    0, 32'h00050040, 0, 1, 4'd2},  // R2 new descriptor
    '{0, 4'h0, 32'h0,        8'h00, 0, 0, 12'd10,   1, 32'h00050040, 1, 1, 4'd8}   // R8 whole packet present
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    host_wr_en = 0; host_be = 0; host_wdata = 0; evb = 0;
    tx_active = 0; mode_100m = 0; fifo_bytes = 0; fifo_pkt_ready = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", host_rdata, 32'h00002000);
    check("R1 tx_start", {31'b0, tx_start}, 32'h0);
    check("R1 next_desc_valid", {31'b0, next_desc_valid}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      host_wr_en = VECS[i].wr; host_be = VECS[i].be; host_wdata = VECS[i].wd;
      evb = VECS[i].ev; tx_active = VECS[i].act; mode_100m = VECS[i].m100;
      fifo_bytes = VECS[i].fb; fifo_pkt_ready = VECS[i].pkt;
      step();
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), host_rdata, VECS[i].er);
      check($sformatf("R%0d vec%0d tx_start", VECS[i].req, i), {31'b0, tx_start}, {31'b0, VECS[i].es});
      check($sformatf("R%0d vec%0d next_desc_valid", VECS[i].req, i),
            {31'b0, next_desc_valid}, {31'b0, VECS[i].evld});
    end

    // R8 packet flag still high, already fired: no second pulse
    drive_idle(); fifo_pkt_ready = 1;
    step();
    check("R8 no repeat", {31'b0, tx_start}, 32'h0);

    // R6 saturation after 17 collisions
    drive_idle(); tx_active = 1; evb = E_COL;
    repeat (17) step();
    drive_idle();
    step();
    check("R6 saturate at 15", host_rdata, 32'h0F050040);

    // R4 write overrides DMA done in the same cycle
    drive_idle(); host_wr_en = 1; host_be = 4'hF; host_wdata = 32'h00050040; evb = E_DMA;
    step();
    drive_idle();
    check("R4 write beats dma_done", host_rdata, 32'h00050040);

    // R1 reset mid-run, with a whole packet present and nothing armed
    rst_n = 0;
    @(negedge clk);
    rst_n = 1; fifo_pkt_ready = 1;
    step();
    check("R1 rdata after reset", host_rdata, 32'h00002000);
    step();
    check("R8 unarmed no start", {31'b0, tx_start}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule